// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block generates the column address for each beat of a DDR2 read or write burst. A one-cycle start pulse captures the starting column address together with the programmed burst length (4 or 8) and burst type (sequential or interleaved). From the next clock the block presents one column address per cycle and flags the final beat. Reads and writes use the same ordering.

The column bits above the burst block stay fixed for the whole burst, and the beats wrap inside the block. For a burst of 4 the block is four columns wide. For a burst of 8 it is eight columns wide. An 8-beat sequential burst wraps inside each 4-column half, and then moves to the other half. An 8-beat interleaved burst XORs the full 3-bit offset. A new burst may be requested on the final beat of the current one, so that bursts run back to back with no gap.

Top module: `ddr_burst_col_seq`

## Requirements
- R1: While rst_ni is low, valid_o and last_o are 0.
- R2: When start_i is accepted at a clock edge, the next cycle shows valid_o=1 with col_o equal to the captured col_i. valid_o then stays high for exactly L consecutive cycles, where L=4 if bl8_i=0 and L=8 if bl8_i=1.
- R3: During a burst, col_o[COL_W-1:2] equals the captured start bits when L=4, and col_o[COL_W-1:3] equals the captured start bits when L=8.
- R4: With interleave_i=0 and L=4, on beat k (k counts from 0) col_o[1:0] = (start[1:0]+k) mod 4.
- R5: With interleave_i=0 and L=8, on beat k col_o[1:0] = (start[1:0]+k) mod 4 and col_o[2] = start[2] XOR k[2]. For example, start 5 gives the offsets 5,6,7,4,1,2,3,0.
- R6: With interleave_i=1, on beat k col_o[1:0] = start[1:0] XOR k[1:0]. For L=8, col_o[2] = start[2] XOR k[2].
- R7: last_o is 1 on the final beat (k=L-1) and at no other time.
- R8: A start_i asserted while last_o=1 is accepted. The new burst's first beat follows in the next cycle, with no idle cycle in between.
- R9: A start_i asserted on a beat other than the final one is ignored. The running burst continues with unchanged addresses and length.
- R10: If start_i is low on the final beat, valid_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst request pulse |
| col_i | input | COL_W | Starting column address |
| bl8_i | input | 1 | Burst length: 0 selects 4, 1 selects 8 |
| interleave_i | input | 1 | Burst type: 0 selects sequential, 1 selects interleaved |
| valid_o | output | 1 | A beat address is present |
| col_o | output | COL_W | Column address of the current beat (0 when idle) |
| last_o | output | 1 | The current beat is the final one |

## Verification
The main function is exercised with all eight start offsets under each of the four length and type combinations. The upper column bits are random, which shows whether they leak into the offset logic or get altered by the wrap. Directed bursts starting at offset 5 separate nibble-wrapped sequential order from a plain 8-column increment, and separate both from XOR order. Bursts run both with idle gaps and chained on the last beat, and some carry a stray start request in mid-burst. Together these distinguish correct chaining from gap insertion and from a request being accepted mid-burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned OFS_W = 3;  // widest in-block offset (burst of 8)

  typedef struct packed {
    logic bl8;
    logic ilv;
  } burst_mode_t;
endpackage

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
  import bcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bl8_q_i,
  output logic             accept_o,
  output logic             active_o,
  output logic             last_o,
  output logic [OFS_W-1:0] cnt_o
);
  logic             active_q;
  logic [OFS_W-1:0] cnt_q;
  logic [OFS_W-1:0] last_idx;

  assign last_idx = bl8_q_i ? OFS_W'(7) : OFS_W'(3);
  assign last_o   = active_q && (cnt_q == last_idx);
  assign accept_o = start_i && (!active_q || last_o);
  assign active_o = active_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (last_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q <= last_idx)); // R2
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (cnt_q == '0)); // R10
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
(
  input  logic [OFS_W-1:0] start_ofs_i,
  input  logic [OFS_W-1:0] cnt_i,
  input  burst_mode_t      mode_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [1:0] lo_seq, lo_ilv, lo;
  logic       hi_flip;

  assign lo_seq = start_ofs_i[1:0] + cnt_i[1:0];  // wraps inside the nibble
  assign lo_ilv = start_ofs_i[1:0] ^ cnt_i[1:0];
  assign lo     = mode_i.ilv ? lo_ilv : lo_seq;
  // bit 2 toggles after four beats in both 8-beat orders; it is fixed for 4-beat bursts
  assign hi_flip = mode_i.bl8 & cnt_i[2];
  assign ofs_o   = {start_ofs_i[2] ^ hi_flip, lo};
endmodule

// File: rtl/ddr_burst_col_seq.sv
module ddr_burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             bl8_i,
  input  logic             interleave_i,
  output logic             valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  localparam int unsigned HI_W = COL_W - OFS_W;

  logic [COL_W-1:0] col_q;
  burst_mode_t      mode_q;
  logic             accept;
  logic             active;
  logic             last;
  logic [OFS_W-1:0] cnt;
  logic [OFS_W-1:0] ofs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      mode_q <= '0;
    end else if (accept) begin
      col_q  <= col_i;
      mode_q <= '{bl8: bl8_i, ilv: interleave_i};
    end
  end

  bcs_beat_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .bl8_q_i (mode_q.bl8),
    .accept_o(accept),
    .active_o(active),
    .last_o  (last),
    .cnt_o   (cnt)
  );

  bcs_addr_gen u_addr (
    .start_ofs_i(col_q[OFS_W-1:0]),
    .cnt_i      (cnt),
    .mode_i     (mode_q),
    .ofs_o      (ofs)
  );

  assign valid_o = active;
  assign last_o  = last;
  assign col_o   = active ? {col_q[COL_W-1:OFS_W], ofs} : '0;

  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R7
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o); // R10
  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (!valid_o || last_o)) |=> (valid_o && col_o == $past(col_i))); // R2
  AST_BLOCK_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> (col_o[COL_W-1:OFS_W] == $past(col_o[COL_W-1:OFS_W]))); // R3
  AST_MID_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && valid_o && !last_o) |=> valid_o); // R9

  if (HI_W < 1) begin : g_bad_width
    initial $error("COL_W must exceed the burst offset width");
  end
endmodule

// File: tb/ddr_burst_col_seq_test.sv
module ddr_burst_col_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic bl8_i = 1'b0;
  logic interleave_i = 1'b0;
  logic valid_o;
  logic [COL_W-1:0] col_o;
  logic last_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_burst_col_seq #(.COL_W(COL_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .col_i(col_i),
    .bl8_i(bl8_i), .interleave_i(interleave_i),
    .valid_o(valid_o), .col_o(col_o), .last_o(last_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input bit b8,
                                               input bit il, input int k);
    logic [2:0] kk, o;
    kk = 3'(k);
    if (il) o = {s[2] ^ (b8 & kk[2]), s[1:0] ^ kk[1:0]};
    else    o = {s[2] ^ (b8 & kk[2]), 2'(s[1:0] + kk[1:0])};
    return {s[COL_W-1:3], o};
  endfunction

  // At a negedge: present a start; caller then runs the beats.
  task automatic run_beats(input logic [COL_W-1:0] s, input bit b8, input bit il,
                           input bit stray, input bit chain_next,
                           input logic [COL_W-1:0] ns, input bit nb8, input bit nil);
    int len;
    len = b8 ? 8 : 4;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk(valid_o == 1'b1, "R2 valid", valid_o, 1);
      chk(col_o == exp_col(s, b8, il, k),
          il ? "R6 interleaved addr" : (b8 ? "R5 seq8 addr" : "R4 seq4 addr"),
          col_o, exp_col(s, b8, il, k));
      chk(col_o[COL_W-1:2] == exp_col(s, b8, il, 0) >> 2 || b8, "R3 block bits bl4",
          col_o[COL_W-1:2], s[COL_W-1:2]);
      chk(last_o == (k == len-1), "R7 last flag", last_o, k == len-1);
      if (stray && k == 1) begin
        start_i = 1'b1;  // R9: must be ignored
        col_i = ~s;
        bl8_i = ~b8;
        interleave_i = ~il;
      end
      if (chain_next && k == len-1) begin
        start_i = 1'b1;  // R8
        col_i = ns;
        bl8_i = nb8;
        interleave_i = nil;
      end
    end
  endtask

  task automatic start_at_negedge(input logic [COL_W-1:0] s, input bit b8, input bit il);
    start_i = 1'b1;
    col_i = s;
    bl8_i = b8;
    interleave_i = il;
  endtask

  initial begin
    logic [COL_W-1:0] s, ns;
    bit b8, il, nb8, nil, chain, stray;
    logic [2:0] dir_seq [8];
    logic [2:0] dir_ilv [8];
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid in reset", valid_o, 0);
    chk(last_o == 1'b0, "R1 last in reset", last_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 idle after reset", valid_o, 0);

    // Directed: start 5, burst of 8, both orders
    dir_seq = '{3'd5, 3'd6, 3'd7, 3'd4, 3'd1, 3'd2, 3'd3, 3'd0};
    dir_ilv = '{3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0, 3'd3, 3'd2};
    start_at_negedge(10'h2a5 & ~10'h7 | 10'h5, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk(col_o[2:0] == dir_seq[k], "R5 directed nibble order", col_o[2:0], dir_seq[k]);
      if (k == 7) start_at_negedge(10'h0c5, 1'b1, 1'b1);  // R8 chained
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk(valid_o == 1'b1, "R8 no gap", valid_o, 1);
      chk(col_o == {7'(10'h0c5 >> 3), dir_ilv[k]}, "R6 directed xor order", col_o,
          {7'(10'h0c5 >> 3), dir_ilv[k]});
    end
    @(negedge clk);
    chk(valid_o == 1'b0, "R10 idle after last", valid_o, 0);
    chk(col_o == '0, "R10 col zero idle", col_o, 0);

    // All offsets, all modes, with stray mid-burst starts
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 8; o++) begin
        s = {7'($urandom), 3'(o)};
        b8 = m[1]; il = m[0];
        start_at_negedge(s, b8, il);
        run_beats(s, b8, il, (o % 3) == 0, 1'b0, '0, 1'b0, 1'b0);
        @(negedge clk);
        chk(valid_o == 1'b0, "R10 gap after burst", valid_o, 0);
      end
    end

    // Random bursts, some chained
    chain = 1'b0;
    s = COL_W'($urandom); b8 = 1'($urandom); il = 1'($urandom);
    for (int i = 0; i < 300; i++) begin
      if (!chain) start_at_negedge(s, b8, il);
      ns = COL_W'($urandom); nb8 = 1'($urandom); nil = 1'($urandom);
      stray = ($urandom % 4) == 0;
      chain = ($urandom % 2) == 0;
      run_beats(s, b8, il, stray, chain, ns, nb8, nil);
      if (!chain) begin
        @(negedge clk);
        chk(valid_o == 1'b0, "R10 idle", valid_o, 0);
      end
      s = ns; b8 = nb8; il = nil;
    end
    if (chain) begin
      run_beats(s, b8, il, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      @(negedge clk);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule